// File: doc/BRIEF.md
# Interrupt Level Acceptance Unit

This unit decides which peripheral interrupt the processor takes next. Every source presents a request flag and its own 3-bit level. Smaller level numbers are more urgent: 0 is the most urgent and 7 the least. The unit picks the most urgent pending request. It takes that request only when two conditions hold: the interrupt-enable bit of the condition-code byte is set, and the request's level is strictly smaller than the current level mask.

An accepted request yields a one-cycle accept pulse that carries the source index and the level. On the same clock edge the mask takes the accepted level, so from then on only strictly more urgent requests can get through. Software can overwrite the mask from an 8-bit immediate. A return-from-interrupt strobe restores a saved mask value.

A 16-bit status view combines three fields: the mask, the register-bank pointer and the condition-code byte. The accept output has no ready input and applies no back-pressure. The consumer must take each pulse in the cycle it appears. Sources hold their own requests, and the unit latches nothing, so a request that is withdrawn is never taken.

Top module: `irq_level_gate`

## Requirements
- R1: Reset clears the mask to 0 and the accept pulse to 0. While the mask is 0, no request is ever accepted.
- R2: A request is accepted only when bit 6 of `ccr_in` is 1 and its level is strictly less than the current mask.
- R3: The level of source i is `req_level[3*i+2:3*i]`, and `acc_level` reports exactly that value for the winning source.
- R4: When a request is accepted in cycle n, `acc_valid` is high in cycle n+1, and `cur_mask` equals the accepted level from cycle n+1 on.
- R5: When `mask_wr` is high (and `reti` is low), `cur_mask` takes `mask_wdata[2:0]` on the next edge. Bits 7:3 are dropped.
- R6: `status_word` equals {`cur_mask`, `bank_ptr`, `ccr_in`}: the mask in bits 15:13, the bank pointer in bits 12:8 and the condition-code byte in bits 7:0.
- R7: Among eligible requests, the smallest level wins. When levels are equal, the lowest source index wins.
- R8: `acc_valid` lasts exactly one cycle, and no acceptance is made in the cycle that shows an accept pulse.
- R9: A high `reti` loads `cur_mask` with `reti_mask` on the next edge. It takes precedence over a software write and over an acceptance, and no acceptance is made in that cycle.
- R10: No acceptance is made in a cycle in which `mask_wr` is high.
- R11: A request that is withdrawn before it is accepted is never accepted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_SRC | Per-source request flags |
| req_level | input | 3*NUM_SRC | Per-source levels, 3 bits each, source 0 in the low bits |
| ccr_in | input | 8 | Condition-code byte; bit 6 is the global interrupt enable |
| bank_ptr | input | 5 | Register-bank pointer, used only in the status view |
| mask_wr | input | 1 | Software write strobe for the mask |
| mask_wdata | input | 8 | Immediate value for the mask; only bits 2:0 are kept |
| reti | input | 1 | Return-from-interrupt restore strobe |
| reti_mask | input | 3 | Saved mask value to restore |
| acc_valid | output | 1 | One-cycle accept pulse |
| acc_src | output | SRC_W | Index of the accepted source |
| acc_level | output | 3 | Level of the accepted source |
| cur_mask | output | 3 | Current level mask |
| status_word | output | 16 | Packed processor-status view |

## Verification
The mask is the only internal state that has consequences. Any error in it shows up directly on `cur_mask` and in bits 15:13 of `status_word` one cycle after the faulty update. It also changes which request is accepted, or whether one is accepted at all, within a cycle or two. An error in the back-to-back lockout appears as two adjacent accept pulses, and a wrong arbitration choice appears on `acc_src` in the pulse cycle. The bench compares every output against a cycle model on every cycle, so any of these errors is caught at the first cycle it becomes visible.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int LVL_W   = 3;
  localparam int CCR_W   = 8;
  localparam int BANK_W  = 5;
  localparam int WDATA_W = 8;
  localparam int IE_BIT  = 6;
  localparam int STAT_W  = LVL_W + BANK_W + CCR_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_gate_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input  logic [NUM_SRC-1:0]       req_valid,
  input  logic [NUM_SRC*LVL_W-1:0] req_level,
  output logic                     found,
  output logic [SRC_W-1:0]         best_idx,
  output lvl_t                     best_lvl
);
  lvl_t lvl_arr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign lvl_arr[g] = req_level[g*LVL_W +: LVL_W];
  end

  // Strict compare keeps the earlier (lower) index on ties.
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_lvl = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_valid[i] && (!found || lvl_arr[i] < best_lvl)) begin
        found    = 1'b1;
        best_idx = SRC_W'(i);
        best_lvl = lvl_arr[i];
      end
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reti,
  input  lvl_t               reti_val,
  input  logic               wr,
  input  logic [WDATA_W-1:0] wr_data,
  input  logic               take,
  input  lvl_t               take_lvl,
  output lvl_t               mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mask <= '0;
    else if (reti) mask <= reti_val;
    else if (wr)   mask <= wr_data[LVL_W-1:0];
    else if (take) mask <= take_lvl;
  end

  AST_WRITE_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !reti) |=> mask == $past(wr_data[LVL_W-1:0])); // R5
endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_gate_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       req_valid,
  input  logic [NUM_SRC*LVL_W-1:0] req_level,
  input  logic [CCR_W-1:0]         ccr_in,
  input  logic [BANK_W-1:0]        bank_ptr,
  input  logic                     mask_wr,
  input  logic [WDATA_W-1:0]       mask_wdata,
  input  logic                     reti,
  input  logic [LVL_W-1:0]         reti_mask,
  output logic                     acc_valid,
  output logic [SRC_W-1:0]         acc_src,
  output logic [LVL_W-1:0]         acc_level,
  output logic [LVL_W-1:0]         cur_mask,
  output logic [STAT_W-1:0]        status_word
);
  logic             found;
  logic [SRC_W-1:0] best_idx;
  lvl_t             best_lvl;
  logic             fire;

  irq_pick #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pick (
    .req_valid (req_valid),
    .req_level (req_level),
    .found     (found),
    .best_idx  (best_idx),
    .best_lvl  (best_lvl)
  );

  // The best candidate has the smallest level, so if it fails the mask test, all fail.
  always_comb
    fire = found && ccr_in[IE_BIT] && (best_lvl < cur_mask)
           && !reti && !mask_wr && !acc_valid;

  irq_mask_reg u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .reti     (reti),
    .reti_val (reti_mask),
    .wr       (mask_wr),
    .wr_data  (mask_wdata),
    .take     (fire),
    .take_lvl (best_lvl),
    .mask     (cur_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_src   <= '0;
      acc_level <= '0;
    end else begin
      acc_valid <= fire;
      if (fire) begin
        acc_src   <= best_idx;
        acc_level <= best_lvl;
      end
    end
  end

  assign status_word = {cur_mask, bank_ptr, ccr_in};

  AST_ZERO_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mask == '0) |=> !acc_valid); // R1
  AST_ACC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(ccr_in[IE_BIT])); // R2
  AST_ACC_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> acc_level < $past(cur_mask)); // R2
  AST_MASK_TAKES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> cur_mask == acc_level); // R4
  AST_PICK_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> req_valid[best_idx]); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> !acc_valid); // R8
  AST_RETI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reti |=> (!acc_valid && cur_mask == $past(reti_mask))); // R9
  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> !acc_valid); // R10
endmodule

// File: tb/sim_irq_level_gate.sv
`timescale 1ns/1ps
module sim_irq_level_gate;
  localparam int N = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   req_valid = '0;
  logic [3*N-1:0] req_level = '0;
  logic [7:0]     ccr_in = '0;
  logic [4:0]     bank_ptr = '0;
  logic           mask_wr = 1'b0;
  logic [7:0]     mask_wdata = '0;
  logic           reti = 1'b0;
  logic [2:0]     reti_mask = '0;
  logic           acc_valid;
  logic [SW-1:0]  acc_src;
  logic [2:0]     acc_level;
  logic [2:0]     cur_mask;
  logic [15:0]    status_word;

  always #2.5 clk = ~clk;

  irq_level_gate #(.NUM_SRC(N)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0] m_mask;
  logic       m_accv;
  logic [2:0] m_src, m_lvl;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void pick(input logic [N-1:0] v, input logic [3*N-1:0] l,
                               output bit f, output logic [2:0] idx, output logic [2:0] lv);
    f = 0; idx = 0; lv = 7;
    for (int i = 0; i < N; i++) begin
      logic [2:0] x;
      x = l[3*i +: 3];
      if (v[i] && (!f || x < lv)) begin f = 1; idx = 3'(i); lv = x; end
    end
  endfunction

  // Drive one cycle at negedge, advance the model, check outputs at next negedge.
  task automatic step(logic [N-1:0] v, logic [3*N-1:0] l, logic [7:0] ccr, logic [4:0] bk,
                      logic wr, logic [7:0] wd, logic rt, logic [2:0] rm);
    bit f; logic [2:0] idx, lv; bit fire;
    req_valid = v; req_level = l; ccr_in = ccr; bank_ptr = bk;
    mask_wr = wr; mask_wdata = wd; reti = rt; reti_mask = rm;
    #1;
    check("R6 status_word", int'(status_word), int'({m_mask, bk, ccr}));
    pick(v, l, f, idx, lv);
    fire = f && ccr[6] && (lv < m_mask) && !rt && !wr && !m_accv;
    if (rt) m_mask = rm;
    else if (wr) m_mask = wd[2:0];
    else if (fire) m_mask = lv;
    m_accv = fire;
    if (fire) begin m_src = idx; m_lvl = lv; end
    @(negedge clk);
    check("R2 acc_valid", int'(acc_valid), int'(m_accv));
    if (m_accv) begin
      check("R7 acc_src", int'(acc_src), int'(m_src));
      check("R3 acc_level", int'(acc_level), int'(m_lvl));
    end
    check("R4 cur_mask", int'(cur_mask), int'(m_mask));
  endtask

  function automatic logic [3*N-1:0] one_lvl(int s, logic [2:0] lv);
    logic [3*N-1:0] r = '0;
    r[3*s +: 3] = lv;
    return r;
  endfunction

  initial begin
    logic [3*N-1:0] lv2;
    void'($urandom(32'd4099));
    m_mask = 0; m_accv = 0; m_src = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    check("R1 reset acc_valid", int'(acc_valid), 0);
    check("R1 reset cur_mask", int'(cur_mask), 0);
    rst_n = 1'b1;
    // R1: mask 0 blocks even level-0 requests
    step('1, '0, 8'h40, 5'd3, 0, 0, 0, 0);
    check("R1 blocked at mask 0", int'(acc_valid), 0);
    // R5: only low 3 bits stored (0xFD -> 5)
    step('0, '0, 8'h40, 5'd3, 1, 8'hFD, 0, 0);
    check("R5 low bits", int'(cur_mask), 5);
    // R10: write with eligible request blocks acceptance
    step(8'h01, one_lvl(0, 3'd1), 8'h40, 0, 1, 8'h06, 0, 0);
    check("R10 write blocks", int'(acc_valid), 0);
    // R2: enable bit clear blocks
    step(8'h01, one_lvl(0, 3'd1), 8'h00, 0, 0, 0, 0, 0);
    check("R2 enable off", int'(acc_valid), 0);
    // R7: tie at level 3 between sources 2 and 5 goes to 2
    lv2 = one_lvl(2, 3'd3) | one_lvl(5, 3'd3) | one_lvl(6, 3'd7);
    step(8'h64, lv2, 8'h40, 0, 0, 0, 0, 0);
    check("R7 tie index", int'(acc_src), 2);
    check("R4 mask took level", int'(cur_mask), 3);
    // R8 and R11: level-0 request appears only in the pulse cycle, then drops
    step(8'h10, one_lvl(4, 3'd0), 8'h40, 0, 0, 0, 0, 0);
    check("R8 no back-to-back", int'(acc_valid), 0);
    step('0, '0, 8'h40, 0, 0, 0, 0, 0);
    check("R11 dropped not taken", int'(acc_valid), 0);
    // R9: reti with an eligible request
    step(8'h02, one_lvl(1, 3'd0), 8'h40, 0, 1, 8'h01, 1, 3'd6);
    check("R9 reti blocks acc", int'(acc_valid), 0);
    check("R9 reti value", int'(cur_mask), 6);
    step(8'h02, one_lvl(1, 3'd0), 8'h40, 0, 0, 0, 0, 0);
    check("R4 accept after reti", int'(acc_valid), 1);
    step('0, '0, 8'h40, 0, 0, 0, 0, 0);
    check("R8 pulse width", int'(acc_valid), 0);
    // Random phase
    for (int c = 0; c < 4000; c++) begin
      logic [7:0] ccr;
      ccr = 8'($urandom);
      ccr[6] = ($urandom % 4) != 0;
      step(N'($urandom & $urandom), (3*N)'($urandom), ccr, 5'($urandom),
           ($urandom % 8) == 0, 8'($urandom), ($urandom % 16) == 0, 3'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule